// File: doc/BRIEF.md
# Display Hot-Plug Interrupt Unit

This unit watches the sense lines of two digital display connectors and turns attach and detach events into interrupts. Each sense line is brought into the clock domain through a two-stage synchronizer. When a channel is enabled, its synchronized level shows in a status register that software can read. Software programs a polarity for each channel, and the channel latches a pending interrupt once the live level matches that polarity.

The usual driver flow is as follows. Software sets the polarity to wait for the opposite of the current state. When the interrupt arrives, it acknowledges the channel and flips the polarity. In this way each connect and each disconnect is reported once. The pending flags of all channels are collected into a display interrupt status word. A sticky summary bit in a global status register drives the interrupt line, and software clears that bit by writing its value back.

All registers sit on a simple word-addressed write port with a combinational read port. The number of channels is a parameter.

Top module: `hpd_irq_unit`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq_o` is low.
- R2: While a channel's detect-enable bit (bit 0 at channel offset 0) is 0, the channel's sense status reads 0 and its pending flag cannot become set.
- R3: The sense status (bit 0 at channel offset 1) reads 1 while the channel is enabled and the synchronized sense input is 1. A level change applied before clock edge n is visible after edge n+1.
- R4: The interrupt-control register (channel offset 2) stores interrupt enable in bit 0 and polarity in bit 1, and both read back. Bit 2 is the acknowledge bit, which is write-one and always reads 0.
- R5: With detect enabled and interrupt enable 1, the pending flag sets on the first edge at which the synchronized sense matches the polarity, where polarity 0 matches sense 1 and polarity 1 matches sense 0. Once set, the flag stays set, even if the match ends or the channel is disabled.
- R6: Writing 1 to the acknowledge bit clears the pending flag at that edge. If the match still holds afterwards, the flag sets again on the next edge.
- R7: The display interrupt status word (address 4·NUM_CH) reports channel c's pending flag in bit c. Writes to it have no effect.
- R8: The global status register (address 4·NUM_CH+1) has a summary bit in bit 0. This bit sets on the edge after any pending flag is 1, and a write with bit 0 set clears it. If a pending flag is still 1, the bit sets again on the following edge. `irq_o` equals this bit.
- R9: Channel c's registers sit at address 4c plus the offset, and the channels operate independently. Any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_i | input | NUM_CH | Asynchronous connector sense lines, 1 = display attached |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for `addr_i` |
| irq_o | output | 1 | Global display interrupt line |

## Verification
The hardest case to reach is an acknowledge written while the match condition still holds. The flag must drop for exactly one cycle and then come back. To reach it, the stimulus holds the sense line steady and writes the acknowledge bit while keeping the same polarity. It then reads the status word on the two cycles that follow. A second write flips the polarity together with the acknowledge, so the re-arm does not happen.

The same pattern is applied to the global summary bit. Its clear is written while one channel is still pending. The stimulus also disables a channel that is pending and checks that the flag stays set. A later acknowledge on that disabled channel must not set the flag again.

// File: rtl/hpd_pkg.sv
package hpd_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned CH_STRIDE = 4;

    // register offsets inside one channel window
    localparam int unsigned OFS_CTRL = 0;
    localparam int unsigned OFS_STAT = 1;
    localparam int unsigned OFS_ICTL = 2;

    // field positions
    localparam int unsigned BIT_DET_EN = 0;
    localparam int unsigned BIT_SENSE  = 0;
    localparam int unsigned BIT_IE     = 0;
    localparam int unsigned BIT_POL    = 1;
    localparam int unsigned BIT_ACK    = 2;
    localparam int unsigned BIT_SUMM   = 0;

    typedef struct packed {
        logic det_en;
        logic ie;
        logic pol;
    } hpd_cfg_t;

    typedef struct packed {
        logic sense;
        logic pending;
    } hpd_stat_t;

    // polarity 0 waits for attach (sense 1), polarity 1 waits for detach
    function automatic logic level_match(logic sense, logic pol);
        return sense ^ pol;
    endfunction

    function automatic int unsigned chan_addr(int unsigned ch, int unsigned ofs);
        return ch * CH_STRIDE + ofs;
    endfunction

endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hpd_channel.sv
module hpd_channel
    import hpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sense_sync_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_ictl_i,
    input  logic [DATA_W-1:0] wdata_i,
    output hpd_cfg_t          cfg_o,
    output hpd_stat_t         stat_o
);
    hpd_cfg_t cfg;
    logic     pending;
    logic     ack;
    logic     hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (wr_ctrl_i) cfg.det_en <= wdata_i[BIT_DET_EN];
            if (wr_ictl_i) begin
                cfg.ie  <= wdata_i[BIT_IE];
                cfg.pol <= wdata_i[BIT_POL];
            end
        end
    end

    assign ack = wr_ictl_i & wdata_i[BIT_ACK];
    assign hit = cfg.det_en & cfg.ie & level_match(sense_sync_i, cfg.pol);

    // acknowledge wins; a persisting match re-arms one edge later
    always_ff @(posedge clk) begin
        if (rst)      pending <= 1'b0;
        else if (ack) pending <= 1'b0;
        else if (hit) pending <= 1'b1;
    end

    assign cfg_o          = cfg;
    assign stat_o.sense   = cfg.det_en & sense_sync_i;
    assign stat_o.pending = pending;

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ack |=> !pending); // R6
    AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pending && !ack) |=> pending); // R5
    AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!cfg.det_en && !pending) |=> !pending); // R2
    AST_NO_SET_WITHOUT_IE: assert property (@(posedge clk) disable iff (rst)
        (!cfg.ie && !pending) |=> !pending); // R5
endmodule

// File: rtl/hpd_summary.sv
module hpd_summary #(
    parameter int unsigned NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pend_i,
    input  logic              clr_i,
    output logic              flag_o
);
    logic any_pend;
    logic flag;

    assign any_pend = |pend_i;

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (clr_i)    flag <= 1'b0;
        else if (any_pend) flag <= 1'b1;
    end

    assign flag_o = flag;

    AST_SUMMARY_SETS: assert property (@(posedge clk) disable iff (rst)
        (any_pend && !clr_i) |=> flag); // R8
    AST_SUMMARY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !flag); // R8
    AST_SUMMARY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_i) |=> flag); // R8
endmodule

// File: rtl/hpd_irq_unit.sv
module hpd_irq_unit
    import hpd_pkg::*;
#(
    parameter int unsigned NUM_CH      = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CH-1:0]     sense_i,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic                  irq_o
);
    localparam int unsigned DISP_ADDR = NUM_CH * CH_STRIDE;
    localparam int unsigned GLOB_ADDR = DISP_ADDR + 1;

    hpd_cfg_t          cfg  [NUM_CH];
    hpd_stat_t         stat [NUM_CH];
    logic [NUM_CH-1:0] pend_vec;
    logic              summ_flag;
    logic              glob_clr;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic sense_sync;
            logic wr_ctrl;
            logic wr_ictl;

            hpd_sync #(.STAGES(SYNC_STAGES)) sync_i (
                .clk (clk),
                .rst (rst),
                .d_i (sense_i[c]),
                .q_o (sense_sync)
            );

            assign wr_ctrl = wr_en_i && (addr_i == ADDR_W'(chan_addr(c, OFS_CTRL)));
            assign wr_ictl = wr_en_i && (addr_i == ADDR_W'(chan_addr(c, OFS_ICTL)));

            hpd_channel chan_i (
                .clk          (clk),
                .rst          (rst),
                .sense_sync_i (sense_sync),
                .wr_ctrl_i    (wr_ctrl),
                .wr_ictl_i    (wr_ictl),
                .wdata_i      (wdata_i),
                .cfg_o        (cfg[c]),
                .stat_o       (stat[c])
            );

            assign pend_vec[c] = stat[c].pending;
        end
    endgenerate

    assign glob_clr = wr_en_i && (addr_i == ADDR_W'(GLOB_ADDR)) && wdata_i[BIT_SUMM];

    hpd_summary #(.NUM_CH(NUM_CH)) summ_i (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend_vec),
        .clr_i  (glob_clr),
        .flag_o (summ_flag)
    );

    always_comb begin
        rdata_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr_i == ADDR_W'(chan_addr(c, OFS_CTRL)))
                rdata_o[BIT_DET_EN] = cfg[c].det_en;
            if (addr_i == ADDR_W'(chan_addr(c, OFS_STAT)))
                rdata_o[BIT_SENSE] = stat[c].sense;
            if (addr_i == ADDR_W'(chan_addr(c, OFS_ICTL))) begin
                rdata_o[BIT_IE]  = cfg[c].ie;
                rdata_o[BIT_POL] = cfg[c].pol;
            end
        end
        if (addr_i == ADDR_W'(DISP_ADDR))
            rdata_o[NUM_CH-1:0] = pend_vec;
        if (addr_i == ADDR_W'(GLOB_ADDR))
            rdata_o[BIT_SUMM] = summ_flag;
    end

    assign irq_o = summ_flag;

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(|pend_vec)); // R8
endmodule

// File: tb/hpd_irq_unit_tb_top.sv
module hpd_irq_unit_tb_top;

    localparam int unsigned NCH = 2;
    localparam int unsigned AW  = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCH-1:0]  sense_i = '0;
    logic            wr_en_i = 1'b0;
    logic [AW-1:0]   addr_i = '0;
    logic [31:0]     wdata_i = '0;
    logic [31:0]     rdata_o;
    logic            irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hpd_irq_unit #(.NUM_CH(NCH), .SYNC_STAGES(2), .ADDR_W(AW)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .sense_i (sense_i),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    // op: 0 write, 1 read-check, 2 set sense, 3 irq-check
    typedef struct packed {
        logic [1:0] op;
        logic [3:0] addr;
        logic [7:0] data;
        logic [3:0] req;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 50;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 4'd0, 8'd0, 4'd1, 8'd0},  //  0 R1 ctrl0 reset
        '{2'd1, 4'd8, 8'd0, 4'd1, 8'd0},  //  1 R1 disp word reset
        '{2'd1, 4'd9, 8'd0, 4'd1, 8'd0},  //  2 R1 global reset
        '{2'd3, 4'd0, 8'd0, 4'd1, 8'd0},  //  3 R1 irq low
        '{2'd2, 4'd0, 8'd1, 4'd0, 8'd0},  //  4 attach ch0
        '{2'd1, 4'd1, 8'd0, 4'd2, 8'd0},  //  5 R2 disabled sense 0
        '{2'd1, 4'd1, 8'd0, 4'd2, 8'd0},  //  6 R2
        '{2'd0, 4'd0, 8'd1, 4'd0, 8'd0},  //  7 enable ch0
        '{2'd1, 4'd1, 8'd0, 4'd3, 8'd1},  //  8 R3 sense visible
        '{2'd1, 4'd8, 8'd0, 4'd5, 8'd0},  //  9 R5 ie off, nothing
        '{2'd0, 4'd2, 8'd1, 4'd0, 8'd0},  // 10 ie=1 pol=0
        '{2'd1, 4'd8, 8'd0, 4'd5, 8'd0},  // 11 R5 not yet
        '{2'd1, 4'd8, 8'd0, 4'd5, 8'd1},  // 12 R5 pending
        '{2'd1, 4'd9, 8'd0, 4'd8, 8'd1},  // 13 R8 summary
        '{2'd3, 4'd0, 8'd0, 4'd8, 8'd1},  // 14 R8 irq
        '{2'd1, 4'd2, 8'd0, 4'd4, 8'd1},  // 15 R4 readback
        '{2'd0, 4'd2, 8'd5, 4'd0, 8'd0},  // 16 ack, keep ie
        '{2'd1, 4'd8, 8'd0, 4'd6, 8'd0},  // 17 R6 cleared
        '{2'd1, 4'd8, 8'd0, 4'd6, 8'd1},  // 18 R6 re-armed
        '{2'd0, 4'd2, 8'd7, 4'd0, 8'd0},  // 19 ack + pol=1
        '{2'd1, 4'd8, 8'd0, 4'd6, 8'd0},  // 20 R6
        '{2'd1, 4'd8, 8'd0, 4'd5, 8'd0},  // 21 R5 no match
        '{2'd1, 4'd2, 8'd0, 4'd4, 8'd3},  // 22 R4 ack reads 0
        '{2'd0, 4'd9, 8'd1, 4'd0, 8'd0},  // 23 clear summary
        '{2'd1, 4'd9, 8'd0, 4'd8, 8'd0},  // 24 R8
        '{2'd3, 4'd0, 8'd0, 4'd8, 8'd0},  // 25 R8 irq low
        '{2'd2, 4'd0, 8'd0, 4'd0, 8'd0},  // 26 detach ch0
        '{2'd1, 4'd1, 8'd0, 4'd3, 8'd1},  // 27 R3 still old
        '{2'd1, 4'd1, 8'd0, 4'd3, 8'd0},  // 28 R3 new level
        '{2'd1, 4'd8, 8'd0, 4'd5, 8'd1},  // 29 R5 detach caught
        '{2'd1, 4'd9, 8'd0, 4'd8, 8'd1},  // 30 R8
        '{2'd0, 4'd8, 8'd0, 4'd0, 8'd0},  // 31 write disp word
        '{2'd1, 4'd8, 8'd0, 4'd7, 8'd1},  // 32 R7 ignored
        '{2'd3, 4'd0, 8'd0, 4'd8, 8'd1},  // 33 R8 irq
        '{2'd0, 4'd4, 8'd1, 4'd0, 8'd0},  // 34 enable ch1
        '{2'd0, 4'd6, 8'd3, 4'd0, 8'd0},  // 35 ch1 ie=1 pol=1
        '{2'd1, 4'd8, 8'd0, 4'd9, 8'd1},  // 36 R9
        '{2'd1, 4'd8, 8'd0, 4'd9, 8'd3},  // 37 R9 both pending
        '{2'd0, 4'd2, 8'd4, 4'd0, 8'd0},  // 38 ack ch0, ie off
        '{2'd1, 4'd8, 8'd0, 4'd6, 8'd2},  // 39 R6 only ch0 cleared
        '{2'd1, 4'd2, 8'd0, 4'd4, 8'd0},  // 40 R4
        '{2'd0, 4'd9, 8'd1, 4'd0, 8'd0},  // 41 clear summary
        '{2'd1, 4'd9, 8'd0, 4'd8, 8'd0},  // 42 R8 cleared
        '{2'd1, 4'd9, 8'd0, 4'd8, 8'd1},  // 43 R8 re-set
        '{2'd0, 4'd4, 8'd0, 4'd0, 8'd0},  // 44 disable ch1
        '{2'd1, 4'd8, 8'd0, 4'd5, 8'd2},  // 45 R5 sticky
        '{2'd1, 4'd5, 8'd0, 4'd2, 8'd0},  // 46 R2 sense hidden
        '{2'd0, 4'd6, 8'd7, 4'd0, 8'd0},  // 47 ack ch1
        '{2'd1, 4'd8, 8'd0, 4'd6, 8'd0},  // 48 R6
        '{2'd1, 4'd8, 8'd0, 4'd2, 8'd0}   // 49 R2 no re-set
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; wdata_i = '0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        addr_i = a;
        #1;
        check(req, rdata_o, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            @(negedge clk);
            v = VECS[i];
            tag = $sformatf("R%0d vec%0d", v.req, i);
            wr_en_i = (v.op == 2'd0);
            addr_i  = v.addr;
            wdata_i = {24'd0, v.data};
            if (v.op == 2'd2) sense_i = v.data[NCH-1:0];
            #1;
            if (v.op == 2'd1) check(tag, rdata_o, {24'd0, v.exp});
            if (v.op == 2'd3) check(tag, {31'd0, irq_o}, {24'd0, v.exp});
        end
        @(negedge clk);
        wr_en_i = 1'b0;

        // R9: unmapped address reads zero
        rd_check("R9 unmapped", 4'd15, 32'd0);

        // R8: raise a fresh interrupt on ch0 (sense 0, polarity 1)
        wr(4'd0, 32'd1);
        wr(4'd2, 32'd3);
        repeat (3) @(negedge clk);
        check("R8 irq before reset", {31'd0, irq_o}, 32'd1);

        // R1: reset in the middle of activity
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd_check("R1 ctrl0", 4'd0, 32'd0);
        rd_check("R1 ictl0", 4'd2, 32'd0);
        rd_check("R1 disp",  4'd8, 32'd0);
        rd_check("R1 global", 4'd9, 32'd0);
        check("R1 irq", {31'd0, irq_o}, 32'd0);

        finish_run();
    end

endmodule